// File: doc/BRIEF.md
# Tanner Graph Four-Cycle Edge Probe

This block keeps a small low-density parity-check matrix in flip-flops and answers one question about it: if an edge were added between bit node `i` (a matrix column, i.e. a codeword bit) and check node `j` (a matrix row, i.e. a parity equation), would that edge close a cycle of length four in the Tanner graph? A set entry of the matrix marks an existing edge. Four is the shortest cycle a bipartite Tanner graph can have, and it is the one a code constructor most wants to avoid. The block is meant for a hardware code builder that proposes edges one at a time, for example while it fills columns of weight three and rows of weight six. The builder keeps only edges the probe clears.

A query enters on a valid/ready handshake carrying the two indices. The block then walks the stored matrix. It scans the bit nodes `k` already joined to check `j`, skipping `k = i`. For each such `k` it scans the checks `l` joined to `k`, skipping `l = j`, and tests whether `l` also touches bit `i`. The walk stops at the first hit. One cycle later a single-cycle `done` pulse appears together with the result bit. The state machine has four states. `ST_IDLE` accepts a query (transition *accept*). `ST_SCAN_BIT` tests one bit node per cycle (transitions *enter-check-scan*, *next-bit*, *bits-exhausted*). `ST_SCAN_CHK` tests one check node per cycle (transitions *hit*, *next-check*, *resume-bit-scan*, *all-exhausted*). `ST_DONE` presents the answer and returns to `ST_IDLE` (transition *retire*). A separate write port sets or clears single matrix entries, but only while the walker is idle.

Top module: `four_cycle_probe`

## Requirements
- R1: After reset, every matrix entry is 0. `q_ready` and `wr_ready` are 1, and `done` and `loop_found` are 0.
- R2: A write accepted while `wr_en` and `wr_ready` are both high stores `wr_val` (1 = edge present, 0 = no edge) at row `wr_chk`, column `wr_bit`. The next query sees the new value.
- R3: At `done`, `loop_found` is 1 exactly when there is a bit `k` ≠ `q_bit` and a check `l` ≠ `q_chk` such that entries (`q_chk`,`k`), (`l`,`k`) and (`l`,`q_bit`) are all 1. Otherwise it is 0.
- R4: Paths through bit `i` itself or through check `j` itself never count. A present entry (`j`,`i`) with no qualifying pair gives 0.
- R5: Each accepted query produces exactly one `done` pulse, one cycle long. `q_ready` is low from the accepting edge through the `done` cycle and is high in the cycle after it.
- R6: When bit 0 is the first candidate (entry (`j`,0) set, `i` ≠ 0) and check 0 completes the path (`j` ≠ 0), `done` rises on the second clock edge after the accepting edge.
- R7: `done` rises no later than N_BITS·(N_CHECKS+1) clock edges after the accepting edge.
- R8: While a search runs, `wr_ready` is low and `wr_en` has no effect on the matrix.
- R9: A query offered while a search runs is not accepted and produces no `done` pulse of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_valid | input | 1 | Query offered |
| q_ready | output | 1 | Walker idle, query will be taken |
| q_bit | input | $clog2(N_BITS) | Candidate bit node `i` (column) |
| q_chk | input | $clog2(N_CHECKS) | Candidate check node `j` (row) |
| done | output | 1 | One-cycle pulse: answer valid |
| loop_found | output | 1 | 1 = candidate edge closes a four-cycle |
| wr_en | input | 1 | Matrix write request |
| wr_ready | output | 1 | Write will be taken this cycle |
| wr_chk | input | $clog2(N_CHECKS) | Row written |
| wr_bit | input | $clog2(N_BITS) | Column written |
| wr_val | input | 1 | Value stored at that entry |

## Verification
The hardest situations to reach from the ports are the collisions: a write or a second query arriving while a search is in flight. A typical search ends in a few cycles, so the stimulus first fills one check row completely, leaving no qualifying path. This forces the longest possible walk of 136 cycles. During that walk the bench drives a write that would create a cycle, and a competing query. Afterwards it repeats the same query to show that the write was dropped. A second hard case is the exact early-exit timing. A dedicated three-edge matrix places the hit on the very first bit and check so that the cycle count is fixed.

// File: rtl/c4_pkg.sv
package c4_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SCAN_BIT = 2'd1,
        ST_SCAN_CHK = 2'd2,
        ST_DONE     = 2'd3
    } walk_state_t;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/c4_matrix_store.sv
module c4_matrix_store #(
    parameter int N_BITS   = 16,
    parameter int N_CHECKS = 8,
    localparam int BW = c4_pkg::idx_w(N_BITS),
    localparam int CW = c4_pkg::idx_w(N_CHECKS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CW-1:0]                wr_chk,
    input  logic [BW-1:0]                wr_bit,
    input  logic                         wr_val,
    output logic [N_CHECKS*N_BITS-1:0]   mat_flat
);

    // one register row per check node, column = bit node
    for (genvar r = 0; r < N_CHECKS; r++) begin : g_row
        logic [N_BITS-1:0] row_q;
        logic              row_sel;

        assign row_sel = wr_en && (int'(wr_chk) == r) && (int'(wr_bit) < N_BITS);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q <= '0;
            end else if (row_sel) begin
                row_q[wr_bit] <= wr_val;
            end
        end

        assign mat_flat[r*N_BITS +: N_BITS] = row_q;
    end

endmodule

// File: rtl/c4_walker.sv
module c4_walker
    import c4_pkg::*;
#(
    parameter int N_BITS   = 16,
    parameter int N_CHECKS = 8,
    localparam int BW = idx_w(N_BITS),
    localparam int CW = idx_w(N_CHECKS),
    localparam int FW = idx_w(N_BITS*N_CHECKS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_CHECKS*N_BITS-1:0]   mat_flat,
    input  logic                         q_valid,
    input  logic [BW-1:0]                q_bit,
    input  logic [CW-1:0]                q_chk,
    output logic                         q_ready,
    output logic                         done,
    output logic                         loop_found
);

    walk_state_t st_q, st_d;
    logic [BW-1:0] i_q, i_d, k_q, k_d;
    logic [CW-1:0] j_q, j_d, l_q, l_d;
    logic          f_q, f_d;

    logic cand_k, hit_l, last_k, last_l;

    function automatic logic hget(input logic [N_CHECKS*N_BITS-1:0] m,
                                  input int r, input int c);
        int idx;
        if (r < N_CHECKS && c < N_BITS) begin
            idx = r * N_BITS + c;
            return m[idx[FW-1:0]];
        end
        return 1'b0;
    endfunction

    // level one: is bit k a neighbour of check j (and not i itself)?
    assign cand_k = (k_q != i_q) && hget(mat_flat, int'(j_q), int'(k_q));
    // levels two and three: does check l join k and i (and is not j)?
    assign hit_l  = (l_q != j_q)
                 && hget(mat_flat, int'(l_q), int'(k_q))
                 && hget(mat_flat, int'(l_q), int'(i_q));
    assign last_k = (k_q == BW'(N_BITS - 1));
    assign last_l = (l_q == CW'(N_CHECKS - 1));

    // next-state and datapath
    always_comb begin
        st_d = st_q;
        i_d  = i_q;
        j_d  = j_q;
        k_d  = k_q;
        l_d  = l_q;
        f_d  = f_q;
        unique case (st_q)
            ST_IDLE: begin
                if (q_valid) begin
                    i_d  = q_bit;
                    j_d  = q_chk;
                    k_d  = '0;
                    l_d  = '0;
                    f_d  = 1'b0;
                    st_d = ST_SCAN_BIT;
                end
            end
            ST_SCAN_BIT: begin
                if (cand_k) begin
                    l_d  = '0;
                    st_d = ST_SCAN_CHK;
                end else if (last_k) begin
                    st_d = ST_DONE;
                end else begin
                    k_d = k_q + BW'(1);
                end
            end
            ST_SCAN_CHK: begin
                if (hit_l) begin
                    f_d  = 1'b1;
                    st_d = ST_DONE;
                end else if (last_l) begin
                    if (last_k) begin
                        st_d = ST_DONE;
                    end else begin
                        k_d  = k_q + BW'(1);
                        st_d = ST_SCAN_BIT;
                    end
                end else begin
                    l_d = l_q + CW'(1);
                end
            end
            ST_DONE: begin
                st_d = ST_IDLE;
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            i_q  <= '0;
            j_q  <= '0;
            k_q  <= '0;
            l_q  <= '0;
            f_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            i_q  <= i_d;
            j_q  <= j_d;
            k_q  <= k_d;
            l_q  <= l_d;
            f_q  <= f_d;
        end
    end

    // outputs
    always_comb begin
        q_ready    = (st_q == ST_IDLE);
        done       = (st_q == ST_DONE);
        loop_found = f_q;
    end

endmodule

// File: rtl/four_cycle_probe.sv
module four_cycle_probe #(
    parameter int N_BITS   = 16,
    parameter int N_CHECKS = 8,
    localparam int BW = c4_pkg::idx_w(N_BITS),
    localparam int CW = c4_pkg::idx_w(N_CHECKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          q_valid,
    output logic          q_ready,
    input  logic [BW-1:0] q_bit,
    input  logic [CW-1:0] q_chk,
    output logic          done,
    output logic          loop_found,
    input  logic          wr_en,
    output logic          wr_ready,
    input  logic [CW-1:0] wr_chk,
    input  logic [BW-1:0] wr_bit,
    input  logic          wr_val
);

    logic [N_CHECKS*N_BITS-1:0] mat_flat;
    logic                       walk_idle;
    logic                       wr_go;

    // writes only while the walker is parked
    assign wr_ready = walk_idle;
    assign q_ready  = walk_idle;
    assign wr_go    = wr_en && walk_idle;

    c4_matrix_store #(
        .N_BITS   (N_BITS),
        .N_CHECKS (N_CHECKS)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_go),
        .wr_chk   (wr_chk),
        .wr_bit   (wr_bit),
        .wr_val   (wr_val),
        .mat_flat (mat_flat)
    );

    c4_walker #(
        .N_BITS   (N_BITS),
        .N_CHECKS (N_CHECKS)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .mat_flat   (mat_flat),
        .q_valid    (q_valid),
        .q_bit      (q_bit),
        .q_chk      (q_chk),
        .q_ready    (walk_idle),
        .done       (done),
        .loop_found (loop_found)
    );

endmodule

// File: rtl/four_cycle_probe_chk.sv
module four_cycle_probe_chk #(
    parameter int N_BITS   = 16,
    parameter int N_CHECKS = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       q_valid,
    input logic                       q_ready,
    input logic                       wr_ready,
    input logic                       done,
    input logic [N_CHECKS*N_BITS-1:0] mat_flat
);

    localparam int MAX_LAT = N_BITS * (N_CHECKS + 1);

    int wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= 0;
        end else if (q_valid && q_ready) begin
            wait_cnt <= 0;
        end else if (!q_ready) begin
            wait_cnt <= wait_cnt + 1;
        end
    end

    // R5: done lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5 / R9: an accepted query takes the walker busy
    a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && q_ready) |=> !q_ready);

    // R9: done only appears while not accepting
    a_r9_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !q_ready);

    // R8: matrix frozen while writes are held off
    a_r8_matrix_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |=> $stable(mat_flat));

    // R7: search length bound
    a_r7_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wait_cnt <= MAX_LAT));

endmodule

bind four_cycle_probe four_cycle_probe_chk #(
    .N_BITS   (N_BITS),
    .N_CHECKS (N_CHECKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_valid  (q_valid),
    .q_ready  (q_ready),
    .wr_ready (wr_ready),
    .done     (done),
    .mat_flat (mat_flat)
);

// File: tb/four_cycle_probe_tb.sv
module four_cycle_probe_tb;

    localparam int NB = 16;
    localparam int NC = 8;
    localparam int MAX_LAT = NB * (NC + 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       q_valid = 1'b0;
    logic       q_ready;
    logic [3:0] q_bit = '0;
    logic [2:0] q_chk = '0;
    logic       done;
    logic       loop_found;
    logic       wr_en = 1'b0;
    logic       wr_ready;
    logic [2:0] wr_chk = '0;
    logic [3:0] wr_bit = '0;
    logic       wr_val = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    logic bm [NC][NB];

    logic inj_wr = 1'b0;
    logic inj_q  = 1'b0;
    logic inj_wr_ready_seen;

    // {bit[3:0], chk[2:0], expected}
    localparam logic [7:0] VEC [5] = '{
        {4'd3, 3'd0, 1'b1},
        {4'd5, 3'd0, 1'b0},
        {4'd1, 3'd1, 1'b1},
        {4'd2, 3'd0, 1'b0},
        {4'd4, 3'd1, 1'b0}
    };

    four_cycle_probe #(.N_BITS(NB), .N_CHECKS(NC)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .q_valid(q_valid), .q_ready(q_ready), .q_bit(q_bit), .q_chk(q_chk),
        .done(done), .loop_found(loop_found),
        .wr_en(wr_en), .wr_ready(wr_ready), .wr_chk(wr_chk), .wr_bit(wr_bit),
        .wr_val(wr_val)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic model(input int i, input int j);
        for (int k = 0; k < NB; k++)
            for (int l = 0; l < NC; l++)
                if (k != i && l != j && bm[j][k] && bm[l][k] && bm[l][i])
                    return 1'b1;
        return 1'b0;
    endfunction

    task automatic wr(input int c, input int b, input logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_chk = 3'(c); wr_bit = 4'(b); wr_val = v;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        bm[c][b] = v;
    endtask

    task automatic clear_all();
        for (int c = 0; c < NC; c++)
            for (int b = 0; b < NB; b++)
                wr(c, b, 1'b0);
    endtask

    task automatic run_query(input int bi, input int ci,
                             output logic res, output int lat, output int ndone);
        @(negedge clk);
        chk("R5 ready before query", int'(q_ready), 1);
        q_valid = 1'b1; q_bit = 4'(bi); q_chk = 3'(ci);
        @(posedge clk);
        @(negedge clk);
        q_valid = 1'b0;
        lat = 0; ndone = 0; res = 1'b0;
        inj_wr_ready_seen = 1'b1;
        while (lat < 400) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 3) begin
                if (inj_wr) begin
                    inj_wr_ready_seen = wr_ready;
                    wr_en = 1'b1; wr_chk = 3'd1; wr_bit = 4'd3; wr_val = 1'b1;
                end
                if (inj_q) begin
                    q_valid = 1'b1; q_bit = 4'd3; q_chk = 3'd1;
                end
            end
            if (lat == 7) begin
                wr_en = 1'b0;
                q_valid = 1'b0;
            end
            if (done) begin
                ndone++;
                res = loop_found;
                break;
            end
        end
        // the cycle after done: idle again, no second pulse (R5)
        for (int t = 0; t < 4; t++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) ndone++;
            if (t == 0) chk("R5 ready after done", int'(q_ready), 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic r;
        int   lat;
        int   nd;
        for (int c = 0; c < NC; c++)
            for (int b = 0; b < NB; b++)
                bm[c][b] = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 q_ready", int'(q_ready), 1);
        chk("R1 wr_ready", int'(wr_ready), 1);
        chk("R1 done", int'(done), 0);
        chk("R1 loop_found", int'(loop_found), 0);
        run_query(3, 0, r, lat, nd);
        chk("R1 empty matrix result", int'(r), 0);
        chk("R5 single done", nd, 1);

        // fixed small graph for the vector table (R2 loads it)
        wr(0, 1, 1'b1); wr(0, 2, 1'b1); wr(1, 2, 1'b1);
        wr(1, 3, 1'b1); wr(2, 5, 1'b1);
        for (int n = 0; n < 5; n++) begin
            run_query(int'(VEC[n][7:4]), int'(VEC[n][3:1]), r, lat, nd);
            chk((n == 3) ? "R4 existing edge only" : "R3 table vector",
                int'(r), int'(VEC[n][0]));
            chk("R5 one done per query", nd, 1);
        end

        // R2: clear then restore an entry
        wr(1, 3, 1'b0);
        run_query(3, 0, r, lat, nd);
        chk("R2 cleared entry", int'(r), 0);
        wr(1, 3, 1'b1);
        run_query(3, 0, r, lat, nd);
        chk("R2 restored entry", int'(r), 1);

        // R4: path through check j only does not count
        clear_all();
        wr(0, 1, 1'b1); wr(0, 2, 1'b1); wr(1, 1, 1'b1);
        run_query(2, 0, r, lat, nd);
        chk("R4 only l=j path", int'(r), 0);

        // R6: earliest exit timing
        clear_all();
        wr(0, 0, 1'b1); wr(0, 5, 1'b1); wr(1, 0, 1'b1);
        run_query(5, 1, r, lat, nd);
        chk("R6 early result", int'(r), 1);
        chk("R6 early latency", lat, 2);

        // R7/R8/R9: longest walk with collisions injected
        clear_all();
        for (int b = 0; b < NB; b++) wr(0, b, 1'b1);
        wr(1, 0, 1'b1);
        inj_wr = 1'b1; inj_q = 1'b1;
        run_query(0, 0, r, lat, nd);
        inj_wr = 1'b0; inj_q = 1'b0;
        chk("R3 full row no path", int'(r), 0);
        chk("R7 latency bound", int'(lat <= MAX_LAT), 1);
        chk("R8 wr_ready low while busy", int'(inj_wr_ready_seen), 0);
        chk("R9 no extra done", nd, 1);
        run_query(0, 0, r, lat, nd);
        chk("R8 held write had no effect", int'(r), 0);
        wr(1, 3, 1'b1);
        run_query(0, 0, r, lat, nd);
        chk("R2 write after idle", int'(r), 1);

        // R3 sweep on a (3,6)-regular matrix
        clear_all();
        for (int b = 0; b < NB; b++) begin
            wr(b % NC, b, 1'b1);
            wr((b + 3) % NC, b, 1'b1);
            wr((b + 5) % NC, b, 1'b1);
        end
        for (int c = 0; c < NC; c++) begin
            for (int b = 0; b < NB; b++) begin
                run_query(b, c, r, lat, nd);
                chk("R3 regular sweep", int'(r), int'(model(b, c)));
                chk("R7 sweep latency", int'(lat <= MAX_LAT), 1);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule